// File: doc/BRIEF.md
# Protection key access checker

This block decides whether a data access breaks the rights attached to its protection key. It keeps a 32-bit policy mask in a register. The mask holds sixteen 2-bit entries and is rebuilt from four mode inputs whenever a configuration strobe is sampled: key enable, long mode active, write protect, and a nested-translation flag. Each access is then judged combinationally. The block builds a 4-bit index from the access's fault error code, with the page-table user bit placed in the reserved-bit slot. It picks the entry at that index and ANDs it with the two rights bits of the access key.

The outputs are a violation flag and a copy of the error code in which the protection-key bit reports that flag. Page walking, the ordinary permission checks and fault delivery happen elsewhere. The block only precomputes the key policy once per mode change, so the access path stays a shallow lookup.

Top module: `pkey_access_check`

## Requirements
- R1: While reset is asserted the policy mask is zero, and until the first configuration strobe no access reports a violation.
- R2: A strobe taken while key enable or long mode active is 0 loads an all-zero mask, so no violation can follow.
- R3: A strobe taken while the nested-translation flag is 1 loads an all-zero mask, whatever the other mode inputs are.
- R4: Error-code bit positions: present at bit 0, write at 1, user at 2, reserved at 3, fetch at 4, key-violation at 5. The entry index is {fetch, page user bit, user, write}. The present bit and the reserved bit of the incoming code do not affect the verdict.
- R5: An instruction fetch (bit 4 = 1), or an access to a page whose user bit is 0, never reports a violation.
- R6: With the policy enabled, a non-fetch access to a user page reports a violation when the access-disable bit of its key is 1.
- R7: The write-disable bit of the key causes a violation only for a write (bit 1 = 1) on a user page that is not a fetch, and only when the access is from user mode (bit 2 = 1) or write protect was 1 at the last strobe.
- R8: The rights input holds 16 keys. Key k has access-disable at bit 2k and write-disable at bit 2k+1. No other key's bits affect the verdict.
- R9: The mask changes only on the clock edge that samples the strobe high. Mode inputs that change without a strobe have no effect.
- R10: The output error code equals the input code in bits 0 to 4. Bit 5 is 1 exactly when a violation is reported, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Rebuild strobe for the policy mask |
| cfg_key_en | input | 1 | Protection keys enabled |
| cfg_long_mode | input | 1 | Long mode active |
| cfg_wr_protect | input | 1 | Supervisor write protection |
| cfg_nested | input | 1 | Nested translation context, forces an empty policy |
| acc_err_code | input | 6 | Fault error code of the access |
| acc_page_user | input | 1 | User bit from the page tables |
| acc_key | input | 4 | Protection key of the page |
| acc_rights | input | 32 | Key rights register, two bits per key |
| violation | output | 1 | Key violation detected |
| err_code_out | output | 6 | Error code with the key-violation bit merged |

## Verification
All sixteen combinations of the four mode inputs are loaded in turn. Under each one, every combination of the five low error-code bits and the page user bit is applied with random keys and random rights, so that the reserved and present bits are shown to have no effect, and so that fetches and supervisor pages are told apart from user data accesses. Directed accesses with a single rights bit set separate access-disable from write-disable and the key owning the bits from its neighbours. A strobe-timing sequence and mode changes made without a strobe show that the mask moves only on the sampling edge.

// File: rtl/pkey_pkg.sv
package pkey_pkg;
  localparam int NUM_KEYS = 16;
  localparam int KEY_W    = $clog2(NUM_KEYS);
  localparam int RIGHTS_W = 2 * NUM_KEYS;
  localparam int ERR_W    = 6;
  localparam int IDX_W    = 4;
  localparam int ENTRIES  = 1 << IDX_W;
  localparam int MASK_W   = 2 * ENTRIES;

  // error-code bit positions
  localparam int EC_P   = 0;
  localparam int EC_WR  = 1;
  localparam int EC_US  = 2;
  localparam int EC_RSV = 3;
  localparam int EC_F   = 4;
  localparam int EC_PK  = 5;

  // index layout: {fetch, page_user, user, write}
  function automatic logic [IDX_W-1:0] make_index(logic fetch, logic page_user,
                                                  logic user, logic wr);
    return {fetch, page_user, user, wr};
  endfunction

  // entry: bit0 = access-disable enable, bit1 = write-disable enable
  function automatic logic [1:0] entry_bits(logic [IDX_W-1:0] idx, logic wp);
    logic ad_en;
    logic wd_en;
    ad_en = !idx[3] && idx[2];
    wd_en = ad_en && idx[0] && (idx[1] || wp);
    return {wd_en, ad_en};
  endfunction

  function automatic logic policy_on(logic key_en, logic long_mode, logic nested);
    return key_en && long_mode && !nested;
  endfunction
endpackage

// File: rtl/pkey_mask_reg.sv
module pkey_mask_reg
  import pkey_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              key_en,
  input  logic              long_mode,
  input  logic              wr_protect,
  input  logic              nested,
  output logic [MASK_W-1:0] mask_q
);
  logic [MASK_W-1:0] table_w;
  logic              enable_w;

  assign enable_w = policy_on(key_en, long_mode, nested);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    assign table_w[2*e +: 2] = entry_bits(IDX_W'(e), wr_protect);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (load) begin
      mask_q <= enable_w ? table_w : '0;
    end
  end
endmodule

// File: rtl/pkey_entry_sel.sv
module pkey_entry_sel
  import pkey_pkg::*;
(
  input  logic [MASK_W-1:0] mask,
  input  logic [IDX_W-1:0]  idx,
  output logic [1:0]        entry
);
  assign entry = mask[{idx, 1'b0} +: 2];
endmodule

// File: rtl/pkey_rights_sel.sv
module pkey_rights_sel
  import pkey_pkg::*;
(
  input  logic [RIGHTS_W-1:0] rights,
  input  logic [KEY_W-1:0]    key,
  output logic [1:0]          pair
);
  assign pair = rights[{key, 1'b0} +: 2];
endmodule

// File: rtl/pkey_access_check.sv
module pkey_access_check
  import pkey_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_load,
  input  logic                cfg_key_en,
  input  logic                cfg_long_mode,
  input  logic                cfg_wr_protect,
  input  logic                cfg_nested,
  input  logic [ERR_W-1:0]    acc_err_code,
  input  logic                acc_page_user,
  input  logic [KEY_W-1:0]    acc_key,
  input  logic [RIGHTS_W-1:0] acc_rights,
  output logic                violation,
  output logic [ERR_W-1:0]    err_code_out
);
  logic [MASK_W-1:0] mask_q;
  logic [IDX_W-1:0]  lookup_idx;
  logic [1:0]        sel_entry;
  logic [1:0]        key_pair;

  pkey_mask_reg u_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cfg_load),
    .key_en     (cfg_key_en),
    .long_mode  (cfg_long_mode),
    .wr_protect (cfg_wr_protect),
    .nested     (cfg_nested),
    .mask_q     (mask_q)
  );

  assign lookup_idx = make_index(acc_err_code[EC_F], acc_page_user,
                                 acc_err_code[EC_US], acc_err_code[EC_WR]);

  pkey_entry_sel u_entry (
    .mask  (mask_q),
    .idx   (lookup_idx),
    .entry (sel_entry)
  );

  pkey_rights_sel u_rights (
    .rights (acc_rights),
    .key    (acc_key),
    .pair   (key_pair)
  );

  assign violation = |(sel_entry & key_pair);

  always_comb begin
    err_code_out        = acc_err_code;
    err_code_out[EC_PK] = violation;
  end
endmodule

// File: rtl/pkey_access_check_sva.sv
module pkey_access_check_sva
  import pkey_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_load,
  input logic                cfg_key_en,
  input logic                cfg_long_mode,
  input logic                cfg_nested,
  input logic [ERR_W-1:0]    acc_err_code,
  input logic                acc_page_user,
  input logic [KEY_W-1:0]    acc_key,
  input logic [RIGHTS_W-1:0] acc_rights,
  input logic                violation,
  input logic [ERR_W-1:0]    err_code_out,
  input logic [MASK_W-1:0]   mask_q
);
  localparam logic [ERR_W-1:0] KEEP_BITS = ~(ERR_W'(1) << EC_PK);

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_zero_R1: assert (mask_q == '0);
    end
  end

  assert_off_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load && !(cfg_key_en && cfg_long_mode) |=> mask_q == '0);

  assert_nested_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load && cfg_nested |=> mask_q == '0);

  assert_fetch_or_sup_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_err_code[EC_F] || !acc_page_user) |-> !violation);

  assert_needs_key_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    violation |-> (acc_rights[{acc_key, 1'b0}] || acc_rights[{acc_key, 1'b1}]));

  assert_wd_only_writes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    violation && !acc_rights[{acc_key, 1'b0}] |-> acc_err_code[EC_WR]);

  assert_hold_without_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(mask_q));

  assert_code_merge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code_out[EC_PK] == violation) &&
    (((err_code_out ^ acc_err_code) & KEEP_BITS) == '0));
endmodule

bind pkey_access_check pkey_access_check_sva u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_load      (cfg_load),
  .cfg_key_en    (cfg_key_en),
  .cfg_long_mode (cfg_long_mode),
  .cfg_nested    (cfg_nested),
  .acc_err_code  (acc_err_code),
  .acc_page_user (acc_page_user),
  .acc_key       (acc_key),
  .acc_rights    (acc_rights),
  .violation     (violation),
  .err_code_out  (err_code_out),
  .mask_q        (mask_q)
);

// File: tb/tb_pkey_access_check.sv
`timescale 1ns/1ps
module tb_pkey_access_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic        cfg_key_en = 1'b0;
  logic        cfg_long_mode = 1'b0;
  logic        cfg_wr_protect = 1'b0;
  logic        cfg_nested = 1'b0;
  logic [5:0]  acc_err_code = '0;
  logic        acc_page_user = 1'b0;
  logic [3:0]  acc_key = '0;
  logic [31:0] acc_rights = '0;
  logic        violation;
  logic [5:0]  err_code_out;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // model of the mode captured at the last strobe
  bit m_ke = 0, m_lm = 0, m_wp = 0, m_ns = 0;

  always #4 clk = ~clk;

  pkey_access_check dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_key_en(cfg_key_en), .cfg_long_mode(cfg_long_mode),
    .cfg_wr_protect(cfg_wr_protect), .cfg_nested(cfg_nested),
    .acc_err_code(acc_err_code), .acc_page_user(acc_page_user),
    .acc_key(acc_key), .acc_rights(acc_rights),
    .violation(violation), .err_code_out(err_code_out)
  );

  // direct evaluation of the access conditions
  function automatic bit exp_viol(logic [5:0] ec, logic pu, logic [3:0] k, logic [31:0] r);
    bit ad, wd;
    if (!(m_ke && m_lm && !m_ns)) return 0;
    if (ec[4] || !pu) return 0;
    ad = r[2*k];
    wd = r[2*k+1];
    return ad || (wd && ec[1] && (ec[2] || m_wp));
  endfunction

  function automatic string pick_tag(logic [5:0] ec, logic pu);
    if (m_ns) return "R3";
    if (!(m_ke && m_lm)) return "R2";
    if (ec[4] || !pu) return "R5";
    if (ec[1]) return "R7";
    return "R6";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_load(bit ke, bit lm, bit wp, bit ns);
    @(negedge clk);
    cfg_key_en = ke; cfg_long_mode = lm; cfg_wr_protect = wp; cfg_nested = ns;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    m_ke = ke; m_lm = lm; m_wp = wp; m_ns = ns;
  endtask

  task automatic access(logic [5:0] ec, logic pu, logic [3:0] k, logic [31:0] r, string tag);
    bit ev;
    logic [5:0] eo;
    acc_err_code = ec; acc_page_user = pu; acc_key = k; acc_rights = r;
    #1;
    ev = exp_viol(ec, pu, k, r);
    eo = {ev, ec[4:0]};
    check(tag, 32'(violation), 32'(ev));
    check("R10", 32'(err_code_out), 32'(eo));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // R1: in reset, all rights set, user page read
    access(6'b000101, 1'b1, 4'd3, 32'hFFFF_FFFF, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    access(6'b000111, 1'b1, 4'd9, 32'hFFFF_FFFF, "R1");

    // R9: strobe timing, old mask visible until the sampling edge
    @(negedge clk);
    cfg_key_en = 1; cfg_long_mode = 1; cfg_wr_protect = 1; cfg_nested = 0;
    cfg_load = 1'b1;
    access(6'b000100, 1'b1, 4'd2, 32'h0000_0010, "R9");
    @(negedge clk);
    cfg_load = 1'b0;
    m_ke = 1; m_lm = 1; m_wp = 1; m_ns = 0;
    access(6'b000100, 1'b1, 4'd2, 32'h0000_0010, "R9");
    check("R9", 32'(violation), 32'd1);
    // mode changes without strobe have no effect
    @(negedge clk);
    cfg_key_en = 0; cfg_nested = 1;
    repeat (2) @(negedge clk);
    access(6'b000100, 1'b1, 4'd2, 32'h0000_0010, "R9");

    // R4: reserved bit set with a supervisor page, present bit ignored
    access(6'b001100, 1'b0, 4'd2, 32'hFFFF_FFFF, "R4");
    access(6'b000001, 1'b1, 4'd0, 32'h0000_0001, "R4");
    access(6'b000000, 1'b1, 4'd0, 32'h0000_0001, "R4");
    // R8: only the own key bits count
    access(6'b000110, 1'b1, 4'd7, 32'h0000_4000, "R8");
    access(6'b000110, 1'b1, 4'd7, 32'hFFFF_3FFF, "R8");
    access(6'b000110, 1'b1, 4'd7, 32'h0000_8000, "R8");
    // R7: supervisor write, WD only, with wp=0 then wp=1
    do_load(1, 1, 0, 0);
    access(6'b000010, 1'b1, 4'd5, 32'h0000_0800, "R7");
    check("R7", 32'(violation), 32'd0);
    do_load(1, 1, 1, 0);
    access(6'b000010, 1'b1, 4'd5, 32'h0000_0800, "R7");
    check("R7", 32'(violation), 32'd1);

    // sweep every mode and every index combination
    for (int m = 0; m < 16; m++) begin
      do_load(m[0], m[1], m[2], m[3]);
      for (int c = 0; c < 64; c++) begin
        logic [5:0] ec;
        logic [3:0] k;
        logic [31:0] r;
        ec = {1'($urandom), c[4:0]};
        k  = 4'($urandom);
        r  = $urandom;
        access(ec, c[5], k, r, pick_tag(ec, c[5]));
        access(ec, c[5], k, 32'hFFFF_FFFF, pick_tag(ec, c[5]));
      end
    end

    // random mode reloads mixed with random accesses
    for (int i = 0; i < 400; i++) begin
      logic [5:0] ec;
      logic pu;
      logic [3:0] k;
      if (i % 25 == 0) do_load(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      ec = 6'($urandom);
      pu = 1'($urandom);
      k  = 4'($urandom);
      access(ec, pu, k, $urandom, pick_tag(ec, pu));
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule